// File: doc/BRIEF.md
# Receiver Variance Accumulator with Measurement Window

This block measures how noisy a receiver's decisions are over a fixed stretch of time. Each valid signed error sample from the receiver's equalizer is squared and added to a 32-bit accumulator. The measurement runs for a window of 2, 4, 6 or 8 milliseconds, counted in 1 ms ticks, and only while the link is up in the fast mode. At the end of the window the finished sum moves into a holding register and a ready flag is raised. Software then divides a window-dependent constant by the sum and takes the logarithm to obtain a signal-to-noise figure. For that reason the sum is a plain, unscaled total.

Control is a single register write that carries an enable bit and a 2-bit window select. The result comes out through one 16-bit data port that software reads twice. The first read returns the low half and freezes the high half in a shadow register. The second read returns that frozen high half and clears the ready flag. A window that ends while an earlier result is still unread is dropped, so the held value stays intact until software has read it.

The design has three parts. The window timer is a two-state machine. In W_IDLE it stays put until the block is enabled and the link is up, and then takes the transition start into W_RUN. In W_RUN, a control write, loss of enable or loss of link takes the transition abort back to W_IDLE. The Nth tick takes the transition wrap, which stays in W_RUN and pulses the window-done signal. The accumulator squares samples, saturates the sum and publishes it. The read pair machine has the states RD_LO and RD_HI. A data read in RD_LO takes the transition take_low to RD_HI. A data read in RD_HI takes the transition take_high back to RD_LO and clears the ready flag.

Top module: `rx_var_accum`

## Requirements
- R1: After reset, res_ready is 0 and dat_out is 0.
- R2: The window select ctl_win encodes the window length in ticks: 00 = 2, 01 = 4, 10 = 6, 11 = 8. Counting starts when the timer enters W_RUN. res_ready rises one clock after the cycle that carries the Nth tick, and it does not rise at any earlier tick.
- R3: The published sum is the total of err_smp squared, with err_smp read as two's complement, over every cycle in W_RUN with err_vld high. This includes the cycle that carries the final tick.
- R4: The sum saturates at 0xFFFFFFFF instead of wrapping.
- R5: The accumulator clears when a window ends. The next window, which starts at once, contains only its own samples.
- R6: If link_ok goes low, the running window is dropped and nothing is published. When link_ok returns, a fresh window starts with a zero tick count and a zero sum.
- R7: While ctl_en is 0, samples and ticks are ignored. res_ready stays 0 and the held value shown on dat_out does not change.
- R8: While res_ready is 1, a window that ends is discarded. The held value stays unchanged until the pair read completes.
- R9: With dat_rd high, the first read shows the low 16 bits of the held sum on dat_out. The following read shows the high 16 bits of that same sum, taken from a snapshot made at the first read.
- R10: The first read of a pair leaves res_ready set. The second read clears it.
- R11: A control write while a window is running aborts that window. A new window then starts with the newly written select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| link_ok | input | 1 | Link valid in fast mode |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| err_vld | input | 1 | Error sample valid |
| err_smp | input | SW (16) | Signed error sample |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_win | input | 2 | Window select of the control write |
| dat_rd | input | 1 | Data register read strobe |
| dat_out | output | DW (16) | Current half of the held sum |
| res_ready | output | 1 | A finished sum is waiting to be read |

## Verification
Saturation is the condition hardest to reach from the ports. The stimulus reaches it with five samples of the most negative 16-bit value, each squaring to 2^30, inside one 8 ms window. A second hard case is a window that ends while a result is still unread. The bench reaches it by letting two windows finish before reading, and then confirms that the first sum is returned and the next window starts clean. Link loss and control rewrites are injected partway through a window, after some ticks have already been counted. This shows that the partial count and the partial sum are both discarded.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
    typedef enum logic {W_IDLE, W_RUN} win_state_t;
    typedef enum logic {RD_LO, RD_HI} rd_state_t;

    localparam int TICK_CW = 4;

    // window length in ticks: 2, 4, 6, 8
    function automatic logic [TICK_CW-1:0] win_ticks(input logic [1:0] sel);
        return {1'b0, sel, 1'b0} + TICK_CW'(2);
    endfunction
endpackage

// File: rtl/rxv_win_timer.sv
module rxv_win_timer
    import rxv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_ok,
    input  logic       en,
    input  logic [1:0] win_sel,
    input  logic       restart,
    input  logic       tick,
    output logic       run,
    output logic       done
);
    win_state_t           st_q, st_nx;
    logic [TICK_CW-1:0]   cnt_q, tgt_q;
    logic                 abort;

    assign abort = !link_ok || !en || restart;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            W_IDLE: if (!abort) st_nx = W_RUN;     // start
            W_RUN:  if (abort)  st_nx = W_IDLE;    // abort
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= W_IDLE;
        else        st_q <= st_nx;
    end

    // outputs: wrap pulse on the final tick of a window
    always_comb begin
        run  = (st_q == W_RUN);
        done = run && !abort && tick && (cnt_q == tgt_q - TICK_CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= TICK_CW'(2);
        end else if (st_q == W_IDLE) begin
            cnt_q <= '0;
            tgt_q <= win_ticks(win_sel);
        end else if (done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + TICK_CW'(1);
        end
    end

    a_r2_cnt_below_target: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < tgt_q));
    a_r2_target_legal: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tgt_q == 4'd2 || tgt_q == 4'd4 || tgt_q == 4'd6 || tgt_q == 4'd8));
    a_r6_link_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !link_ok) |=> !run);
    a_r11_restart_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (run && restart) |=> !run);
endmodule

// File: rtl/rxv_sq_accum.sv
module rxv_sq_accum #(
    parameter int SW = 16,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 done,
    input  logic                 smp_vld,
    input  logic signed [SW-1:0] smp,
    input  logic                 clr_ready,
    output logic [AW-1:0]        hold,
    output logic                 ready
);
    localparam int SQW = 2 * SW;
    localparam int EW  = ((AW > SQW) ? AW : SQW) + 1;

    logic [AW-1:0]          acc_q, acc_add, hold_q;
    logic                   ready_q;
    logic signed [SQW-1:0]  prod;
    logic [EW-1:0]          sum;
    logic                   publish;

    always_comb begin
        prod    = smp * smp;
        sum     = EW'(acc_q) + EW'($unsigned(prod));
        acc_add = acc_q;
        if (run && smp_vld)
            acc_add = (sum > EW'({AW{1'b1}})) ? {AW{1'b1}} : sum[AW-1:0];
        publish = done && !ready_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            hold_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            acc_q <= (!run || done) ? '0 : acc_add;
            if (publish) hold_q <= acc_add;
            if (publish)        ready_q <= 1'b1;
            else if (clr_ready) ready_q <= 1'b0;
        end
    end

    assign hold  = hold_q;
    assign ready = ready_q;

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (!run || acc_q >= $past(acc_q)));
    a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && !clr_ready) |=> (ready_q && $stable(hold_q)));
    a_r6_no_publish_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(hold_q));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ready && !done) |=> !ready_q);
endmodule

// File: rtl/rxv_rd_pair.sv
module rxv_rd_pair
    import rxv_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd,
    input  logic [2*DW-1:0] hold,
    output logic [DW-1:0]   data,
    output logic            clr_ready
);
    rd_state_t     st_q, st_nx;
    logic [DW-1:0] shadow_q;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            RD_LO: if (rd) st_nx = RD_HI;   // take_low
            RD_HI: if (rd) st_nx = RD_LO;   // take_high
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= RD_LO;
            shadow_q <= '0;
        end else begin
            st_q <= st_nx;
            if (st_q == RD_LO && rd) shadow_q <= hold[2*DW-1:DW];
        end
    end

    always_comb begin
        data      = (st_q == RD_HI) ? shadow_q : hold[DW-1:0];
        clr_ready = (st_q == RD_HI) && rd;
    end

    a_r9_shadow_snap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RD_LO && rd) |=> (st_q == RD_HI && shadow_q == $past(hold[2*DW-1:DW])));
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RD_HI && !rd) |=> (st_q == RD_HI && $stable(shadow_q)));
endmodule

// File: rtl/rx_var_accum.sv
module rx_var_accum
    import rxv_pkg::*;
#(
    parameter int SW = 16,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_ok,
    input  logic                 tick_ms,
    input  logic                 err_vld,
    input  logic signed [SW-1:0] err_smp,
    input  logic                 ctl_wr,
    input  logic                 ctl_en,
    input  logic [1:0]           ctl_win,
    input  logic                 dat_rd,
    output logic [DW-1:0]        dat_out,
    output logic                 res_ready
);
    localparam int AW = 2 * DW;

    logic          en_q;
    logic [1:0]    win_q;
    logic          run, done, clr_ready;
    logic [AW-1:0] hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            win_q <= 2'b00;
        end else if (ctl_wr) begin
            en_q  <= ctl_en;
            win_q <= ctl_win;
        end
    end

    rxv_win_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_ok (link_ok),
        .en      (en_q),
        .win_sel (win_q),
        .restart (ctl_wr),
        .tick    (tick_ms),
        .run     (run),
        .done    (done)
    );

    rxv_sq_accum #(.SW(SW), .AW(AW)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .done      (done),
        .smp_vld   (err_vld),
        .smp       (err_smp),
        .clr_ready (clr_ready),
        .hold      (hold),
        .ready     (res_ready)
    );

    rxv_rd_pair #(.DW(DW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (dat_rd),
        .hold      (hold),
        .data      (dat_out),
        .clr_ready (clr_ready)
    );

    a_r7_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !run);
endmodule

// File: tb/rx_var_accum_test.sv
module rx_var_accum_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n, link_ok, tick_ms, err_vld, ctl_wr, ctl_en, dat_rd;
    logic signed [15:0] err_smp;
    logic [1:0]         ctl_win;
    logic [15:0]        dat_out;
    logic               res_ready;

    rx_var_accum uut (
        .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .tick_ms(tick_ms),
        .err_vld(err_vld), .err_smp(err_smp), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .ctl_win(ctl_win), .dat_rd(dat_rd), .dat_out(dat_out), .res_ready(res_ready)
    );

    int errs = 0;
    int checks = 0;
    logic [31:0] exp_sum;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] satadd(input logic [31:0] a, input logic signed [15:0] v);
        longint s;
        s = longint'(a) + longint'(v) * longint'(v);
        return (s > 64'h0000_0000_FFFF_FFFF) ? 32'hFFFF_FFFF : s[31:0];
    endfunction

    function automatic int ticks_of(input logic [1:0] w);
        return 2 * (int'(w) + 1);
    endfunction

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic start(input logic en, input logic [1:0] w);
        ctl_wr = 1'b1; ctl_en = en; ctl_win = w;
        cyc();
        ctl_wr = 1'b0;
        cyc();
        exp_sum = 32'd0;
    endtask

    task automatic samp(input logic signed [15:0] v);
        err_vld = 1'b1; err_smp = v;
        cyc();
        err_vld = 1'b0;
        exp_sum = satadd(exp_sum, v);
    endtask

    task automatic tick();
        tick_ms = 1'b1;
        cyc();
        tick_ms = 1'b0;
    endtask

    // N-1 ticks with ready low, then the final tick raises ready
    task automatic finish_window(input logic [1:0] w, input string req);
        for (int i = 0; i < ticks_of(w) - 1; i++) tick();
        chk({req, " ready before last tick"}, 32'(res_ready), 32'd0);
        tick();
        chk({req, " ready after last tick"}, 32'(res_ready), 32'd1);
    endtask

    task automatic read_pair(input logic [31:0] expv, input string req);
        dat_rd = 1'b1;
        chk({req, " R9 low half"}, 32'(dat_out), 32'(expv[15:0]));
        cyc();
        chk({req, " R10 ready after first read"}, 32'(res_ready), 32'd1);
        chk({req, " R9 high half"}, 32'(dat_out), 32'(expv[31:16]));
        cyc();
        dat_rd = 1'b0;
        chk({req, " R10 ready after second read"}, 32'(res_ready), 32'd0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [31:0] first;
        void'($urandom(32'd2718));
        rst_n = 1'b0; link_ok = 1'b1; tick_ms = 1'b0; err_vld = 1'b0; err_smp = '0;
        ctl_wr = 1'b0; ctl_en = 1'b0; ctl_win = 2'b00; dat_rd = 1'b0; exp_sum = '0;
        repeat (3) cyc();
        chk("R1 ready at reset", 32'(res_ready), 32'd0);
        chk("R1 data at reset", 32'(dat_out), 32'd0);
        rst_n = 1'b1;
        cyc();

        // R2/R3: directed 2 ms window with mixed signs
        start(1'b1, 2'b00);
        samp(16'sd3); samp(-16'sd4); samp(16'sd1000); samp(-16'sd1);
        finish_window(2'b00, "R2 win00");
        chk("R3 directed sum", exp_sum, 32'd1000026);
        read_pair(exp_sum, "R3 directed");

        // R2: the other three windows, random samples
        for (int w = 1; w < 4; w++) begin
            start(1'b1, 2'(w));
            for (int k = 0; k < 6; k++) samp(16'($urandom));
            finish_window(2'(w), "R2 windows");
            read_pair(exp_sum, "R2 windows");
        end

        // R3: sample on the final tick cycle is included
        start(1'b1, 2'b00);
        samp(16'sd5);
        tick();
        tick_ms = 1'b1; err_vld = 1'b1; err_smp = 16'sd7;
        cyc();
        tick_ms = 1'b0; err_vld = 1'b0;
        chk("R3 ready with last-tick sample", 32'(res_ready), 32'd1);
        read_pair(32'd74, "R3 last-tick sample");

        // R5: the window that follows at once holds only its own samples
        exp_sum = 32'd0;
        samp(-16'sd2);
        finish_window(2'b00, "R5 back-to-back");
        read_pair(32'd4, "R5 cleared accumulator");

        // R4: saturation
        start(1'b1, 2'b11);
        for (int k = 0; k < 5; k++) samp(-16'sd32768);
        finish_window(2'b11, "R4 saturate");
        read_pair(32'hFFFF_FFFF, "R4 saturate");

        // R6: link drop in mid window
        start(1'b1, 2'b01);
        samp(16'sd300); tick(); tick();
        link_ok = 1'b0; cyc(); link_ok = 1'b1; cyc();
        tick(); tick();
        chk("R6 no publish after drop", 32'(res_ready), 32'd0);
        exp_sum = 32'd0;
        samp(16'sd9);
        tick();
        chk("R6 fresh count not done", 32'(res_ready), 32'd0);
        tick();
        chk("R6 fresh window done", 32'(res_ready), 32'd1);
        read_pair(32'd81, "R6 fresh sum");

        // R7: disabled block ignores everything
        start(1'b0, 2'b00);
        for (int k = 0; k < 4; k++) samp(16'sd50);
        for (int k = 0; k < 10; k++) tick();
        chk("R7 ready stays low", 32'(res_ready), 32'd0);
        chk("R7 held value unchanged", 32'(dat_out), 32'd81);

        // R11: control write restarts with the new select
        start(1'b1, 2'b01);
        samp(16'sd100); tick(); tick(); tick();
        start(1'b1, 2'b00);
        samp(16'sd6);
        finish_window(2'b00, "R11 restart");
        read_pair(32'd36, "R11 restart");

        // R8: a second window ends while the first is unread
        start(1'b1, 2'b00);
        samp(16'sd10);
        finish_window(2'b00, "R8 first");
        samp(16'sd20); tick(); tick();
        chk("R8 ready still set", 32'(res_ready), 32'd1);
        chk("R8 low half kept", 32'(dat_out), 32'd100);
        read_pair(32'd100, "R8 kept result");
        exp_sum = 32'd0;
        samp(16'sd3);
        finish_window(2'b00, "R8 after discard");
        read_pair(32'd9, "R8 after discard");

        // R9/R10: pair read split by idle cycles
        start(1'b1, 2'b00);
        samp(16'sd20000); samp(16'sd20000);
        first = exp_sum;
        finish_window(2'b00, "R9 split");
        dat_rd = 1'b1;
        chk("R9 split low", 32'(dat_out), 32'(first[15:0]));
        cyc(); dat_rd = 1'b0;
        cyc(); cyc();
        chk("R10 ready between reads", 32'(res_ready), 32'd1);
        chk("R9 split high", 32'(dat_out), 32'(first[31:16]));
        dat_rd = 1'b1; cyc(); dat_rd = 1'b0;
        chk("R10 ready after split pair", 32'(res_ready), 32'd0);

        // random windows
        for (int it = 0; it < 20; it++) begin
            logic [1:0] w;
            w = 2'($urandom % 4);
            start(1'b1, w);
            for (int k = 0; k < int'($urandom % 12); k++) samp(16'($urandom));
            finish_window(w, "R3 random");
            read_pair(exp_sum, "R3 random");
        end

        report();
        $finish;
    end
endmodule